// File: doc/BRIEF.md
# Repeat Loop Controller

This block keeps the state of a zero-overhead repeat loop for a CPU with 16-bit instructions. It decodes the instructions that set up a loop. A 12-bit iteration count sits in bits 27:16 of the status register. Two address registers hold the first and the last instruction of the loop body. Each register can be loaded by its own instruction, and the three values that software may read back are offered on a read port.

Each cycle the fetch stage presents the address it is about to fetch. If that address is the loop's last instruction and more than one pass remains, the block asks fetch to jump back to the loop's first instruction. In the same cycle it lowers the count by one. On the final pass fetch falls through in sequence and the count reaches zero. A count of zero turns the loop check off. The block takes the rest of the status register as an input and returns it with only the count field replaced.

Top module: `repeat_loop_unit`

## Requirements
- R1: After reset the count field, loop start and loop end are all zero and `redirectValid` is low.
- R2: A valid word whose upper byte is 0x82 loads its low byte into status bits 23:16 and clears bits 27:24 on the next edge. Every other bit of `srOut` always equals the same bit of `srIn`.
- R3: A valid word of the form 0x4n14 loads `regOperand[11:0]` into the count field on the next edge.
- R4: A valid word whose upper byte is 0x8C loads `instrPc + 4 + 2*d` into loop start, where d is the low byte taken as unsigned.
- R5: A valid word whose upper byte is 0x8E loads `instrPc + 4 + 2*d` into loop end, with d taken the same way.
- R6: A valid word of the form 0x0n52, 0x0n62 or 0x0n72 raises `readValid` in the same cycle. `readDest` is n, and `readData` is `modIn`, loop start or loop end respectively. No other word raises `readValid`.
- R7: When `fetchValid` is high, `fetchAddr` equals loop end and the count is above 1, `redirectValid` is high with `redirectPc` equal to loop start in that cycle. The count drops by one on the next edge. With `fetchValid` low nothing happens.
- R8: When the address hits loop end with a count of 1, there is no redirect and the count becomes 0.
- R9: With a count of 0 there is never a redirect, and the count stays at 0.
- R10: If a count-setting instruction coincides with a loop-end hit, the instruction's value is loaded and the decrement is dropped. The redirect for that cycle still happens.
- R11: Words presented with `instrValid` low, and valid words that match none of the encodings above, change no loop state and raise no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is being executed this cycle |
| instrWord | input | 16 | Instruction word |
| instrPc | input | ADDR_W | Address of the executing instruction |
| regOperand | input | DATA_W | Value of the general register named by the instruction |
| modIn | input | DATA_W | Modulo register value offered for read-back |
| srIn | input | SR_W | Status register outside the count field |
| fetchValid | input | 1 | A fetch is issued this cycle |
| fetchAddr | input | ADDR_W | Address of that fetch |
| redirectValid | output | 1 | Replace the next fetch address |
| redirectPc | output | ADDR_W | Replacement fetch address |
| srOut | output | SR_W | Status register with the count field inserted |
| loopStart | output | ADDR_W | Loop start register |
| loopEnd | output | ADDR_W | Loop end register |
| readValid | output | 1 | A read-back move is executing |
| readDest | output | 4 | Destination register index of the move |
| readData | output | DATA_W | Value to write to the destination register |

## Verification
The hardest case to reach is a loop-end hit in the same cycle as a count-setting instruction. To set it up, the stimulus first loads both addresses and a count. It then presents a fetch at loop end and a count-setting word together in one cycle, once for the immediate form and once for the register form. The final-pass boundary is reached by walking a count of three down through passes that hit loop end, with a non-matching fetch and a fetch that has its strobe low placed in between. This shows that only a strobed fetch of the end address consumes a pass.

// File: rtl/rloop_pkg.sv
package rloop_pkg;

  localparam int INSTR_W = 16;

  // upper-byte opcodes of the immediate-operand forms
  localparam logic [7:0] OP_CNT_IMM = 8'h82;
  localparam logic [7:0] OP_LD_START = 8'h8C;
  localparam logic [7:0] OP_LD_END = 8'h8E;

  // register forms: top nibble plus low byte
  localparam logic [3:0] GRP_SYS4 = 4'h4;
  localparam logic [3:0] GRP_SYS0 = 4'h0;
  localparam logic [7:0] FN_CNT_REG = 8'h14;
  localparam logic [7:0] FN_RD_MOD = 8'h52;
  localparam logic [7:0] FN_RD_START = 8'h62;
  localparam logic [7:0] FN_RD_END = 8'h72;

  typedef struct packed {
    logic cntFromImm;
    logic cntFromReg;
    logic setStart;
    logic setEnd;
    logic readMod;
    logic readStart;
    logic readEnd;
  } loopCtl_t;

endpackage

// File: rtl/rloop_decode.sv
module rloop_decode
  import rloop_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output loopCtl_t           ctl,
  output logic [3:0]         regSel,
  output logic [7:0]         immByte
);

  logic [7:0] hiByte;
  logic [3:0] topNib;

  assign hiByte  = instrWord[15:8];
  assign topNib  = instrWord[15:12];
  assign regSel  = instrWord[11:8];
  assign immByte = instrWord[7:0];

  always_comb begin
    ctl = '0;
    if (instrValid) begin
      ctl.cntFromImm = (hiByte == OP_CNT_IMM);
      ctl.setStart   = (hiByte == OP_LD_START);
      ctl.setEnd     = (hiByte == OP_LD_END);
      ctl.cntFromReg = (topNib == GRP_SYS4) && (immByte == FN_CNT_REG);
      ctl.readMod    = (topNib == GRP_SYS0) && (immByte == FN_RD_MOD);
      ctl.readStart  = (topNib == GRP_SYS0) && (immByte == FN_RD_START);
      ctl.readEnd    = (topNib == GRP_SYS0) && (immByte == FN_RD_END);
    end
  end

endmodule

// File: rtl/rloop_path.sv
module rloop_path
  import rloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  loopCtl_t          ctl,
  input  logic [7:0]        immByte,
  input  logic [ADDR_W-1:0] instrPc,
  input  logic [DATA_W-1:0] regOperand,
  input  logic [DATA_W-1:0] modIn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [CNT_W-1:0]  loopCount,
  output logic [ADDR_W-1:0] loopStart,
  output logic [ADDR_W-1:0] loopEnd,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              readValid,
  output logic [DATA_W-1:0] readData
);

  localparam int PC_AHEAD = 4;
  localparam logic [CNT_W-1:0] ONE_PASS = CNT_W'(1);

  logic [CNT_W-1:0]  countQ, countNext;
  logic [ADDR_W-1:0] startQ, endQ, pcTarget;
  logic              endHit;
  logic              unusedHighBits;

  assign unusedHighBits = ^regOperand[DATA_W-1:CNT_W];

  // one shared adder serves both address loads
  assign pcTarget = instrPc + ADDR_W'(PC_AHEAD) + (ADDR_W'(immByte) << 1);

  assign endHit        = fetchValid && (fetchAddr == endQ) && (countQ != '0);
  assign redirectValid = endHit && (countQ > ONE_PASS);
  assign redirectPc    = startQ;

  always_comb begin
    countNext = countQ;
    if (ctl.cntFromImm)      countNext = CNT_W'(immByte);
    else if (ctl.cntFromReg) countNext = regOperand[CNT_W-1:0];
    else if (endHit)         countNext = countQ - ONE_PASS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      startQ <= '0;
      endQ   <= '0;
    end else begin
      countQ <= countNext;
      if (ctl.setStart) startQ <= pcTarget;
      if (ctl.setEnd)   endQ   <= pcTarget;
    end
  end

  always_comb begin
    readData = '0;
    if (ctl.readMod)        readData = modIn;
    else if (ctl.readStart) readData = DATA_W'(startQ);
    else if (ctl.readEnd)   readData = DATA_W'(endQ);
  end

  assign readValid = ctl.readMod || ctl.readStart || ctl.readEnd;
  assign loopCount = countQ;
  assign loopStart = startQ;
  assign loopEnd   = endQ;

endmodule

// File: rtl/repeat_loop_unit.sv
module repeat_loop_unit
  import rloop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SR_W    = 32,
  parameter int CNT_W   = 12,
  parameter int CNT_LSB = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  instrPc,
  input  logic [DATA_W-1:0]  regOperand,
  input  logic [DATA_W-1:0]  modIn,
  input  logic [SR_W-1:0]    srIn,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchAddr,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic [SR_W-1:0]    srOut,
  output logic [ADDR_W-1:0]  loopStart,
  output logic [ADDR_W-1:0]  loopEnd,
  output logic               readValid,
  output logic [3:0]         readDest,
  output logic [DATA_W-1:0]  readData
);

  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  loopCtl_t         ctl;
  logic [7:0]       immByte;
  logic [CNT_W-1:0] loopCount;

  rloop_decode u_decode (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctl        (ctl),
    .regSel     (readDest),
    .immByte    (immByte)
  );

  rloop_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .immByte       (immByte),
    .instrPc       (instrPc),
    .regOperand    (regOperand),
    .modIn         (modIn),
    .fetchValid    (fetchValid),
    .fetchAddr     (fetchAddr),
    .loopCount     (loopCount),
    .loopStart     (loopStart),
    .loopEnd       (loopEnd),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .readValid     (readValid),
    .readData      (readData)
  );

  always_comb begin
    srOut = srIn;
    srOut[CNT_MSB:CNT_LSB] = loopCount;
  end

endmodule

// File: rtl/repeat_loop_unit_chk.sv
module repeat_loop_unit_chk #(
  parameter int ADDR_W  = 32,
  parameter int SR_W    = 32,
  parameter int CNT_W   = 12,
  parameter int CNT_LSB = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [15:0]       instrWord,
  input logic [SR_W-1:0]   srIn,
  input logic [SR_W-1:0]   srOut,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] loopStart,
  input logic [ADDR_W-1:0] loopEnd,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc,
  input logic              readValid
);

  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;
  localparam logic [SR_W-1:0] FIELD_MASK = ((SR_W'(1) << CNT_W) - SR_W'(1)) << CNT_LSB;

  logic [CNT_W-1:0] cnt;
  logic             setsCount, hitsEnd;

  assign cnt       = srOut[CNT_MSB:CNT_LSB];
  assign setsCount = instrValid && ((instrWord[15:8] == 8'h82) ||
                     ((instrWord[15:12] == 4'h4) && (instrWord[7:0] == 8'h14)));
  assign hitsEnd   = fetchValid && (fetchAddr == loopEnd);

  // R7
  redirect_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitsEnd && cnt > CNT_W'(1)) |-> (redirectValid && redirectPc == loopStart));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !setsCount) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R8
  last_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitsEnd && cnt == CNT_W'(1) && !setsCount) |=> (cnt == '0));

  // R9
  idle_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> !redirectValid);

  // R2
  imm_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:8] == 8'h82) |=> (cnt == CNT_W'($past(instrWord[7:0]))));

  // R2
  sr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((srOut & ~FIELD_MASK) == (srIn & ~FIELD_MASK)));

  // R6
  read_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> instrValid);

  // R11
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!instrValid && !hitsEnd) |=> ($stable(loopStart) && $stable(loopEnd) && cnt == $past(cnt)));

endmodule

bind repeat_loop_unit repeat_loop_unit_chk #(
  .ADDR_W  (ADDR_W),
  .SR_W    (SR_W),
  .CNT_W   (CNT_W),
  .CNT_LSB (CNT_LSB)
) u_chk (.*);

// File: tb/test_repeat_loop_unit.sv
`timescale 1ns/1ps
module test_repeat_loop_unit;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instrValid = 1'b0;
  logic [15:0]       instrWord = '0;
  logic [ADDR_W-1:0] instrPc = '0;
  logic [DATA_W-1:0] regOperand = '0;
  logic [DATA_W-1:0] modIn = 32'hBEEF_0042;
  logic [SR_W-1:0]   srIn = 32'hA5A5_5A5A;
  logic              fetchValid = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              redirectValid;
  logic [ADDR_W-1:0] redirectPc;
  logic [SR_W-1:0]   srOut;
  logic [ADDR_W-1:0] loopStart;
  logic [ADDR_W-1:0] loopEnd;
  logic              readValid;
  logic [3:0]        readDest;
  logic [DATA_W-1:0] readData;

  always #4 clk = ~clk;

  repeat_loop_unit i_repeat_loop_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrPc(instrPc), .regOperand(regOperand), .modIn(modIn), .srIn(srIn),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .srOut(srOut), .loopStart(loopStart), .loopEnd(loopEnd),
    .readValid(readValid), .readDest(readDest), .readData(readData)
  );

  typedef enum int {S_CNT, S_START, S_END, S_RDV, S_RPC, S_RVLD, S_RDATA, S_RDEST, S_SR} sel_t;
  typedef struct {
    int          when;
    sel_t        sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  int          idx;
  logic [31:0] act;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(sel_t s);
    case (s)
      S_CNT:   return {20'h0, srOut[27:16]};
      S_START: return loopStart;
      S_END:   return loopEnd;
      S_RDV:   return {31'h0, redirectValid};
      S_RPC:   return redirectPc;
      S_RVLD:  return {31'h0, readValid};
      S_RDATA: return readData;
      S_RDEST: return {28'h0, readDest};
      default: return srOut;
    endcase
  endfunction

  task automatic expectAt(int ahead, sel_t s, logic [31:0] v, string req);
    item_t it;
    it.when = cyc + ahead;
    it.sel = s;
    it.exp = v;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic drive(logic iv, logic [15:0] iw, logic [31:0] pc, logic [31:0] rn,
                       logic fv, logic [31:0] fa);
    @(posedge clk);
    #1;
    instrValid = iv;
    instrWord = iw;
    instrPc = pc;
    regOperand = rn;
    fetchValid = fv;
    fetchAddr = fa;
  endtask

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    idx = 0;
    while (idx < sbq.size()) begin
      if (sbq[idx].when == cyc) begin
        checks++;
        act = observe(sbq[idx].sel);
        if (act !== sbq[idx].exp) begin
          errors++;
          $display("FAIL %s %s actual=%h expected=%h", sbq[idx].req,
                   sbq[idx].sel.name(), act, sbq[idx].exp);
        end
        sbq.delete(idx);
      end else begin
        idx++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state, R9 fetch at zero end address with zero count
    drive(0, 16'h0000, 0, 0, 1, 32'h0);
    expectAt(0, S_RDV, 0, "R9");
    expectAt(0, S_CNT, 0, "R1");
    expectAt(0, S_START, 0, "R1");
    expectAt(0, S_END, 0, "R1");

    // R4 loop start load
    drive(1, 16'h8C10, 32'h1000, 0, 0, 0);
    expectAt(1, S_START, 32'h1024, "R4");
    // R5 loop end load, displacement unsigned
    drive(1, 16'h8EFF, 32'h1002, 0, 0, 0);
    expectAt(1, S_END, 32'h1204, "R5");

    // R6 read-back moves
    drive(1, 16'h0362, 0, 0, 0, 0);
    expectAt(0, S_RVLD, 1, "R6");
    expectAt(0, S_RDEST, 3, "R6");
    expectAt(0, S_RDATA, 32'h1024, "R6");
    drive(1, 16'h0A72, 0, 0, 0, 0);
    expectAt(0, S_RDEST, 32'hA, "R6");
    expectAt(0, S_RDATA, 32'h1204, "R6");
    drive(1, 16'h0552, 0, 0, 0, 0);
    expectAt(0, S_RDEST, 5, "R6");
    expectAt(0, S_RDATA, 32'hBEEF_0042, "R6");

    // R11 unknown valid word changes nothing
    drive(1, 16'h0382, 32'h3000, 32'hFFF, 0, 0);
    expectAt(0, S_RVLD, 0, "R11");
    expectAt(1, S_CNT, 0, "R11");
    expectAt(1, S_START, 32'h1024, "R11");
    expectAt(1, S_END, 32'h1204, "R11");
    // R11 words without the valid strobe
    drive(0, 16'h8C55, 32'h2000, 0, 0, 0);
    expectAt(1, S_START, 32'h1024, "R11");
    drive(0, 16'h0362, 0, 0, 0, 0);
    expectAt(0, S_RVLD, 0, "R11");

    // R3 register form uses only low 12 bits
    drive(1, 16'h4714, 0, 32'hFFFF_FABC, 0, 0);
    expectAt(1, S_CNT, 32'hABC, "R3");
    // R2 immediate form clears the top four bits
    drive(1, 16'h8203, 0, 0, 0, 0);
    expectAt(1, S_CNT, 3, "R2");
    expectAt(1, S_SR, 32'hA003_5A5A, "R2");

    // R7 loop passes
    drive(0, 16'h0, 0, 0, 1, 32'h1204);
    expectAt(0, S_RDV, 1, "R7");
    expectAt(0, S_RPC, 32'h1024, "R7");
    expectAt(1, S_CNT, 2, "R7");
    drive(0, 16'h0, 0, 0, 1, 32'h1100);
    expectAt(0, S_RDV, 0, "R7");
    expectAt(1, S_CNT, 2, "R7");
    drive(0, 16'h0, 0, 0, 0, 32'h1204);
    expectAt(0, S_RDV, 0, "R7");
    expectAt(1, S_CNT, 2, "R7");
    drive(0, 16'h0, 0, 0, 1, 32'h1204);
    expectAt(0, S_RDV, 1, "R7");
    expectAt(1, S_CNT, 1, "R7");
    // R8 final pass falls through
    drive(0, 16'h0, 0, 0, 1, 32'h1204);
    expectAt(0, S_RDV, 0, "R8");
    expectAt(1, S_CNT, 0, "R8");
    // R9 exhausted loop stays idle
    drive(0, 16'h0, 0, 0, 1, 32'h1204);
    expectAt(0, S_RDV, 0, "R9");
    expectAt(1, S_CNT, 0, "R9");

    // R10 instruction write beats decrement
    drive(1, 16'h8205, 0, 0, 0, 0);
    expectAt(1, S_CNT, 5, "R2");
    drive(1, 16'h8209, 0, 0, 1, 32'h1204);
    expectAt(0, S_RDV, 1, "R10");
    expectAt(1, S_CNT, 9, "R10");
    drive(1, 16'h4214, 0, 32'h7, 1, 32'h1204);
    expectAt(0, S_RDV, 1, "R10");
    expectAt(1, S_CNT, 7, "R10");

    // R2 other status bits follow the input
    drive(0, 16'h0, 0, 0, 0, 0);
    srIn = 32'h5FFF_FFFF;
    expectAt(0, S_SR, 32'h5007_FFFF, "R2");

    drive(0, 16'h0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1 pending items actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule